// File: doc/BRIEF.md
# Serial Converter Interface Mode Controller

This block is the digital side of a converter's read-only serial port. The port has three wires: an active-low chip select, a serial clock and a serial data output. The block oversamples the chip-select and serial-clock inputs in its own clock domain. A falling chip select opens a frame and requests a sample from the conversion core, which is modelled by a parallel sample bus and a request strobe. The block then shifts a 16-bit word onto the data pin, one bit per falling serial-clock edge. The word is four zero bits followed by the sample, most significant bit first. While no frame is active the data pin is released, which is shown by a low output enable.

The block has no mode pin and no mode register. Normal operation or power-down is chosen only by how many falling serial-clock edges a frame holds before chip select rises again. A frame released early (after 2 to 9 edges) powers the block down. A frame that starts in power-down is a dummy conversion. It wakes the block only if it lasts through the tenth edge, and its data is never flagged valid. This lets a host use either a 16-pulse burst or a frame of any length.

Top module: `adc_serial_mode_ctrl`

## Requirements
- R1: After reset, `powered_down` is 0, `sdata_oe` is 0 and `frame_valid` is 0.
- R2: A falling `cs_n` opens a frame. `sample_req` pulses for exactly one clock cycle, and within two clock cycles `sdata_oe` is 1 with the first bit on `sdata`.
- R3: After k falling `sclk` edges in a frame (k = 0..15), `sdata` carries bit 15-k of the word {4'b0000, sample_data}. The sample is captured when the frame opens.
- R4: `sdata_oe` is 0 whenever chip select is high and after the 16th falling edge of a frame. Edges beyond the 16th do not change the output.
- R5: If `cs_n` rises after n falling edges, with 2 <= n <= 9, the block enters power-down, whatever its earlier mode.
- R6: In a frame that started in normal mode, a release after n < 2 or n >= 10 edges leaves the block in normal mode. A frame cut short of 16 edges is simply aborted.
- R7: In a frame that started in power-down, a release after n >= 10 edges returns the block to normal mode, and a release after n < 10 edges leaves it powered down.
- R8: `frame_valid` pulses once, one cycle after the 16th falling edge, only in frames that started in normal mode.
- R9: Serial-clock edges while `cs_n` is high have no effect on the mode, the data pin or `frame_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (frame) |
| sclk | input | 1 | Serial clock; data advances on its falling edge |
| sample_data | input | RES_W | Conversion result from the core |
| sample_req | output | 1 | One-cycle request to the core at frame start |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the data pin (0 = high impedance) |
| powered_down | output | 1 | 1 while the block is in power-down mode |
| frame_valid | output | 1 | Pulses after a complete frame with valid data |

## Verification
The bench builds the block with its default values: a 12-bit result, 4 leading zeros, power-down from 2 edges and a keep threshold of 10 edges. Every release point from 0 to 18 falling edges is swept from both starting modes. This covers both mode thresholds, the exact 16-edge frame and overlong frames from both modes. A different data word is used in each frame, so the bit order is checked against many patterns.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_PWRDN  = 1'b1
  } op_mode_e;
endpackage

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter logic IDLE_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= pin;
  end

  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int RES_W  = 12,
  parameter int LEAD_Z = 4,
  localparam int FRAME_LEN = RES_W + LEAD_Z,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             shift,
  input  logic [RES_W-1:0] load_data,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             sdata,
  output logic             oe
);
  logic                 active_q, active_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 step;

  assign step = active_q && shift && !start && !stop &&
                (cnt_q < CNT_W'(FRAME_LEN));

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sh_d     = {{LEAD_Z{1'b0}}, load_data};
    end else if (stop) begin
      active_d = 1'b0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
    end
  end

  assign active = active_q;
  assign cnt    = cnt_q;
  assign done   = step && (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign oe     = active_q && (cnt_q < CNT_W'(FRAME_LEN));
  assign sdata  = oe & sh_q[FRAME_LEN-1];

  assert_cnt_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_LEN));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (oe && cnt_q == '0));
  assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && cnt_q < CNT_W'(LEAD_Z)) |-> !sdata);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import adc_if_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int PD_MIN    = 2,
  parameter int KEEP_MIN  = 10,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_stop,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] rel_cnt,
  output logic             powered_down,
  output logic             frame_valid
);
  op_mode_e mode_q, mode_d;
  logic     wake_q, wake_d;
  logic     valid_q, valid_d;
  logic     early, late;

  assign early = (rel_cnt >= CNT_W'(PD_MIN)) && (rel_cnt < CNT_W'(KEEP_MIN));
  assign late  = (rel_cnt >= CNT_W'(KEEP_MIN));

  always_comb begin
    mode_d  = mode_q;
    wake_d  = wake_q;
    valid_d = frame_done && !wake_q;
    if (frame_start) wake_d = (mode_q == MODE_PWRDN);
    if (frame_stop) begin
      if (early)              mode_d = MODE_PWRDN;
      else if (wake_q && late) mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      wake_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      wake_q  <= wake_d;
      valid_q <= valid_d;
    end
  end

  assign powered_down = (mode_q == MODE_PWRDN);
  assign frame_valid  = valid_q;

  assert_pd_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PWRDN && $past(mode_q) == MODE_NORMAL) |->
    ($past(frame_stop) && $past(rel_cnt) >= CNT_W'(PD_MIN) &&
     $past(rel_cnt) < CNT_W'(KEEP_MIN)));
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && $past(mode_q) == MODE_PWRDN) |->
    ($past(frame_stop) && $past(rel_cnt) >= CNT_W'(KEEP_MIN)));
  assert_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (!wake_q && $past(rel_cnt) == CNT_W'(FRAME_LEN - 1)));
endmodule

// File: rtl/adc_serial_mode_ctrl.sv
module adc_serial_mode_ctrl #(
  parameter int RES_W    = 12,
  parameter int LEAD_Z   = 4,
  parameter int PD_MIN   = 2,
  parameter int KEEP_MIN = 10,
  localparam int FRAME_LEN = RES_W + LEAD_Z,
  localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] sample_data,
  output logic             sample_req,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             powered_down,
  output logic             frame_valid
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             cs_rise, cs_fall, sclk_rise_unused, sclk_fall;
  logic             active, done, stop;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pin_edge #(.IDLE_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_int_n), .pin(cs_n), .rise(cs_rise), .fall(cs_fall));

  pin_edge #(.IDLE_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_int_n), .pin(sclk),
    .rise(sclk_rise_unused), .fall(sclk_fall));

  assign stop       = cs_rise && active;
  assign sample_req = cs_fall && rst_int_n;

  frame_shifter #(.RES_W(RES_W), .LEAD_Z(LEAD_Z)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .start(sample_req), .stop(stop),
    .shift(sclk_fall), .load_data(sample_data), .active(active),
    .cnt(cnt), .done(done), .sdata(sdata), .oe(sdata_oe));

  mode_ctrl #(.FRAME_LEN(FRAME_LEN), .PD_MIN(PD_MIN), .KEEP_MIN(KEEP_MIN)) u_mode (
    .clk(clk), .rst_n(rst_int_n), .frame_start(sample_req), .frame_stop(stop),
    .frame_done(done), .rel_cnt(cnt), .powered_down(powered_down),
    .frame_valid(frame_valid));

  assert_idle_hiz_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n && $past(cs_n)) |-> !sdata_oe);
endmodule

// File: tb/tb_adc_serial_mode_ctrl.sv
module tb_adc_serial_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] sample_data = '0;
  logic        sample_req, sdata, sdata_oe, powered_down, frame_valid;

  int checks = 0, fails = 0, vcnt = 0, scnt = 0;
  logic pd_exp = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_serial_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample_data(sample_data), .sample_req(sample_req), .sdata(sdata),
    .sdata_oe(sdata_oe), .powered_down(powered_down), .frame_valid(frame_valid));

  always @(posedge clk) begin
    if (frame_valid) vcnt <= vcnt + 1;
    if (sample_req)  scnt <= scnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic [11:0] d);
    logic [15:0] w;
    bit wake;
    int v0, s0, vexp;
    string tag;
    w = {4'b0000, d};
    wake = pd_exp;
    sample_data = d;
    v0 = vcnt; s0 = scnt;
    @(negedge clk) cs_n = 1'b0;
    waitn(3);
    chk(scnt == s0 + 1, "R2 sample_req", scnt - s0, 1);
    chk({sdata_oe, sdata} == {1'b1, w[15]}, "R2 first bit", {sdata_oe, sdata}, {1'b1, w[15]});
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b1; waitn(3);
      sclk = 1'b0; waitn(3);
      if (k < 16)
        chk({sdata_oe, sdata} == {1'b1, w[15-k]}, "R3 bit", {sdata_oe, sdata}, {1'b1, w[15-k]});
      else
        chk(sdata_oe == 1'b0, "R4 oe after frame", sdata_oe, 0);
    end
    cs_n = 1'b1;
    waitn(3);
    chk(sdata_oe == 1'b0, "R4 oe cs high", sdata_oe, 0);
    if (n >= 2 && n < 10) begin pd_exp = 1'b1; tag = "R5 mode"; end
    else if (wake) begin
      tag = "R7 mode";
      if (n >= 10) pd_exp = 1'b0;
    end else tag = "R6 mode";
    chk(powered_down == pd_exp, tag, powered_down, pd_exp);
    vexp = (n >= 16 && !wake) ? 1 : 0;
    chk(vcnt - v0 == vexp, "R8 frame_valid", vcnt - v0, vexp);
  endtask

  initial begin
    int v0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    chk(powered_down == 1'b0, "R1 mode", powered_down, 0);
    chk(sdata_oe == 1'b0, "R1 oe", sdata_oe, 0);
    chk(frame_valid == 1'b0, "R1 valid", frame_valid, 0);

    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= 18; n++) begin
        if (s == 1 && !pd_exp) run_frame(4, 12'h3C3);
        if (s == 0 && pd_exp)  run_frame(16, 12'h0F0);
        run_frame(n, 12'(12'hA5C ^ (n * 331) ^ (s * 1365)));
      end
    end

    for (int s = 0; s < 2; s++) begin
      if (s == 1) run_frame(5, 12'h111);
      else if (pd_exp) run_frame(16, 12'h222);
      v0 = vcnt;
      for (int k = 0; k < 6; k++) begin
        sclk = 1'b1; waitn(3);
        sclk = 1'b0; waitn(3);
        chk(sdata_oe == 1'b0, "R9 oe idle", sdata_oe, 0);
      end
      chk(powered_down == pd_exp, "R9 mode idle", powered_down, pd_exp);
      chk(vcnt == v0, "R9 valid idle", vcnt - v0, 0);
      run_frame(16, 12'hFFF);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule